// File: doc/BRIEF.md
# Pixel pack, expand and merge unit

This unit reformats partitioned SIMD operands between fixed-point and pixel representations. Three packing variants turn signed fixed-point lanes into saturated values. One gives unsigned 8-bit pixels from 16-bit lanes, and one gives unsigned 8-bit pixels from 32-bit lanes, inserted into a shifted copy of the first operand. The third gives signed 16-bit values from 32-bit lanes. An expand variant widens bytes into 16-bit fixed-point lanes, and a merge variant interleaves the bytes of two 32-bit words.

Each packing variant scales its lanes by a left shift taken from a field of a graphics control word, then applies its own fixed right shift and clamp. The unit accepts one operation per cycle and returns the registered result one cycle later, together with a valid flag and a flag for an unrecognised operation code.

Top module: `pixfmt_unit`

## Requirements
- R1: `valid_out` equals `valid_in` of the previous cycle. While `rst_n` is low at a clock edge, `result`, `valid_out` and `illegal_out` are cleared to zero.
- R2: Codes 0x03B (pack16), 0x03A (pack32), 0x03D (fixed pack), 0x04D (expand) and 0x04B (merge) are recognised. Any other code with `valid_in` high gives `result` = 0 and `illegal_out` = 1 in the next cycle. A recognised code gives `illegal_out` = 0.
- R3: pack16 (0x03B): each signed 16-bit lane i of `opb` is shifted left by the 4-bit scale, then arithmetically right by 7, then clamped to 0..255, and the value goes to `result[8i+7:8i]`. `result[63:32]` is zero.
- R4: pack32 (0x03A): each signed 32-bit lane i of `opb` is shifted left by the 5-bit scale, then arithmetically right by 23, then clamped to 0..255. `result` is `opa` shifted left by 8 with bytes 0 and 4 replaced by the clamped values of lanes 0 and 1.
- R5: fixed pack (0x03D): each signed 32-bit lane i of `opb` is shifted left by the 5-bit scale, then arithmetically right by 16, then saturated to -32768..32767, and the value goes to `result[16i+15:16i]`. `result[63:32]` is zero.
- R6: expand (0x04D): byte i of `opb[31:0]` appears as bits 11:4 of 16-bit lane i of `result`. All other bits of the lane are zero.
- R7: merge (0x04B): for i = 0..3, `result[16i+7:16i]` is byte i of `opb` and `result[16i+15:16i+8]` is byte i of `opa`.
- R8: Intermediate scaled values lose no bits for any scale value, so a shift of up to 31 saturates correctly.
- R9: With `valid_in` low, `result` keeps its value and `illegal_out` is low in the next cycle, whatever the operation code.
- R10: The scale is `ctl_in[6:3]` for pack16 and `ctl_in[7:3]` for the other packs. All other `ctl_in` bits have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| valid_in | input | 1 | Operation present this cycle |
| op_code | input | 9 | Operation select |
| opa | input | 64 | First source operand |
| opb | input | 64 | Second source operand |
| ctl_in | input | CTL_W (32) | Graphics control word carrying the scale field |
| result | output | 64 | Registered result |
| valid_out | output | 1 | Result valid, one cycle after `valid_in` |
| illegal_out | output | 1 | Unrecognised operation code was issued |

## Verification
The assertions assume that `valid_in` and `op_code` are known at every clock edge once reset is released. They also assume that operands sampled with `valid_in` high are stable for the whole of that cycle. The stimulus meets both conditions: it changes inputs only on the falling edge, and it drives defined values from time zero. The stimulus sweeps every scale value for each pack variant, including the widest scale. It combines each scale with lanes at the signed extremes, at the clamp edges and at random values. It also sets the unused control bits, which keeps the scale field isolation exercised.

// File: rtl/pixfmt_pkg.sv
// Shared constants for the pixel formatting unit.
// Assumes the 9-bit operation code and a scale field starting at bit 3.
package pixfmt_pkg;
    typedef enum logic [8:0] {
        OP_PACK16  = 9'h03B,
        OP_PACK32  = 9'h03A,
        OP_PACKFIX = 9'h03D,
        OP_EXPAND  = 9'h04D,
        OP_MERGE   = 9'h04B
    } pixfmt_op_e;

    localparam int DATA_W     = 64;
    localparam int SCALE_LSB  = 3;
    localparam int SCALE16_W  = 4;
    localparam int SCALE32_W  = 5;
endpackage

// File: rtl/pixfmt_lane_pack.sv
// One lane of a saturating pack: sign-extend, scale left, shift right, clamp.
// Assumes the internal width LANE_W + 2**SCALE_W holds every shifted value exactly.
module pixfmt_lane_pack #(
    parameter int LANE_W  = 16,
    parameter int SCALE_W = 4,
    parameter int SHR     = 7,
    parameter int OUT_W   = 8,
    parameter longint MIN_V = 0,
    parameter longint MAX_V = 255
) (
    input  logic [LANE_W-1:0]  lane_in,
    input  logic [SCALE_W-1:0] scale,
    output logic [OUT_W-1:0]   packed_out
);
    localparam int WIDE_W = LANE_W + (1 << SCALE_W);
    localparam logic signed [WIDE_W-1:0] LO_W = WIDE_W'(MIN_V);
    localparam logic signed [WIDE_W-1:0] HI_W = WIDE_W'(MAX_V);

    logic signed [WIDE_W-1:0] ext_v;
    logic signed [WIDE_W-1:0] shl_v;
    logic signed [WIDE_W-1:0] shr_v;

    // Scale the lane and clamp it into the output range.
    always_comb begin
        ext_v = {{(WIDE_W-LANE_W){lane_in[LANE_W-1]}}, lane_in};
        shl_v = ext_v <<< scale;
        shr_v = shl_v >>> SHR;
        if (shr_v < LO_W)
            packed_out = LO_W[OUT_W-1:0];
        else if (shr_v > HI_W)
            packed_out = HI_W[OUT_W-1:0];
        else
            packed_out = shr_v[OUT_W-1:0];
    end
endmodule

// File: rtl/pixfmt_byte_ops.sv
// Byte widening (expand) and byte interleave (merge) of 32-bit operands.
// Assumes sources are the low 32 bits of each operand; purely combinational.
module pixfmt_byte_ops #(
    parameter int BYTES = 4
) (
    input  logic [8*BYTES-1:0]  src_a,
    input  logic [8*BYTES-1:0]  src_b,
    output logic [16*BYTES-1:0] expand_q,
    output logic [16*BYTES-1:0] merge_q
);
    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        // Widen byte i into lane i with four fraction bits.
        assign expand_q[16*i +: 16] = {4'b0000, src_b[8*i +: 8], 4'b0000};
        // Pair byte i of each source, second source low.
        assign merge_q[16*i +: 16]  = {src_a[8*i +: 8], src_b[8*i +: 8]};
    end
endmodule

// File: rtl/pixfmt_unit.sv
// Pixel pack, expand and merge unit: decodes the operation, selects one
// combinational result and registers it with valid and illegal flags.
// Assumes one operation per cycle; the scale field sits at ctl_in[SCALE_LSB+:5].
module pixfmt_unit
    import pixfmt_pkg::*;
#(
    parameter int CTL_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid_in,
    input  logic [8:0]        op_code,
    input  logic [63:0]       opa,
    input  logic [63:0]       opb,
    input  logic [CTL_W-1:0]  ctl_in,
    output logic [63:0]       result,
    output logic              valid_out,
    output logic              illegal_out
);
    localparam int P16_LANES = DATA_W / 16;
    localparam int P32_LANES = DATA_W / 32;
    localparam int CTL_TOP   = SCALE_LSB + SCALE32_W;

    logic [SCALE16_W-1:0]  scale16;
    logic [SCALE32_W-1:0]  scale32;
    logic [8*P16_LANES-1:0]  p16_q;
    logic [8*P32_LANES-1:0]  p32_q;
    logic [16*P32_LANES-1:0] pfix_q;
    logic [63:0] expand_q;
    logic [63:0] merge_q;
    logic [63:0] res_c;
    logic        illegal_c;
    logic        unused_bits;

    assign scale16 = ctl_in[SCALE_LSB +: SCALE16_W];
    assign scale32 = ctl_in[SCALE_LSB +: SCALE32_W];
    assign unused_bits = ^{opa[63:56], ctl_in[SCALE_LSB-1:0], ctl_in[CTL_W-1:CTL_TOP]};

    for (genvar g = 0; g < P16_LANES; g++) begin : g_p16
        pixfmt_lane_pack #(
            .LANE_W(16), .SCALE_W(SCALE16_W), .SHR(7), .OUT_W(8),
            .MIN_V(0), .MAX_V(255)
        ) u_lane (
            .lane_in(opb[16*g +: 16]), .scale(scale16), .packed_out(p16_q[8*g +: 8])
        );
    end

    for (genvar g = 0; g < P32_LANES; g++) begin : g_p32
        pixfmt_lane_pack #(
            .LANE_W(32), .SCALE_W(SCALE32_W), .SHR(23), .OUT_W(8),
            .MIN_V(0), .MAX_V(255)
        ) u_lane (
            .lane_in(opb[32*g +: 32]), .scale(scale32), .packed_out(p32_q[8*g +: 8])
        );
        pixfmt_lane_pack #(
            .LANE_W(32), .SCALE_W(SCALE32_W), .SHR(16), .OUT_W(16),
            .MIN_V(-32768), .MAX_V(32767)
        ) u_fix (
            .lane_in(opb[32*g +: 32]), .scale(scale32), .packed_out(pfix_q[16*g +: 16])
        );
    end

    pixfmt_byte_ops #(.BYTES(4)) u_bytes (
        .src_a(opa[31:0]), .src_b(opb[31:0]),
        .expand_q(expand_q), .merge_q(merge_q)
    );

    // Select the result for the requested operation.
    always_comb begin
        illegal_c = 1'b0;
        res_c     = '0;
        case (op_code)
            OP_PACK16:  res_c = {32'h0, p16_q};
            OP_PACK32:  res_c = {opa[55:32], p32_q[15:8], opa[23:0], p32_q[7:0]};
            OP_PACKFIX: res_c = {32'h0, pfix_q};
            OP_EXPAND:  res_c = expand_q;
            OP_MERGE:   res_c = merge_q;
            default:    illegal_c = 1'b1;
        endcase
    end

    // Register outputs; result holds while no operation is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result      <= '0;
            valid_out   <= 1'b0;
            illegal_out <= 1'b0;
        end else begin
            valid_out   <= valid_in;
            illegal_out <= valid_in & illegal_c;
            if (valid_in)
                result <= res_c;
        end
    end
endmodule

// File: rtl/pixfmt_unit_chk.sv
// Timing and format checks for pixfmt_unit, attached with bind.
// Assumes inputs are known at each clock edge after reset.
module pixfmt_unit_chk
    import pixfmt_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        valid_in,
    input logic [8:0]  op_code,
    input logic [63:0] opa,
    input logic [63:0] result,
    input logic        valid_out,
    input logic        illegal_out
);
    AST_VALID_RISE: assert property (@(posedge clk) disable iff (!rst_n) valid_in |=> valid_out); // R1
    AST_VALID_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !valid_in |=> !valid_out); // R1
    AST_ILLEGAL_ZERO: assert property (@(posedge clk) disable iff (!rst_n) illegal_out |-> (result == 64'h0) && valid_out); // R2
    AST_PACK16_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (valid_in && op_code == OP_PACK16) |=> result[63:32] == 32'h0); // R3
    AST_PACK32_KEEP: assert property (@(posedge clk) disable iff (!rst_n) (valid_in && op_code == OP_PACK32) |=> (result[31:8] == $past(opa[23:0])) && (result[63:40] == $past(opa[55:32]))); // R4
    AST_EXPAND_FRAC: assert property (@(posedge clk) disable iff (!rst_n) (valid_in && op_code == OP_EXPAND) |=> (result & 64'hF00F_F00F_F00F_F00F) == 64'h0); // R6
    AST_MERGE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) (valid_in && op_code == OP_MERGE) |=> result[15:8] == $past(opa[7:0])); // R7
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n) !valid_in |=> $stable(result) && !illegal_out); // R9
endmodule

bind pixfmt_unit pixfmt_unit_chk u_chk (
    .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_code(op_code),
    .opa(opa), .result(result), .valid_out(valid_out), .illegal_out(illegal_out)
);

// File: tb/pixfmt_unit_bench.sv
module pixfmt_unit_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid_in = 1'b0;
    logic [8:0]  op_code = 9'h0;
    logic [63:0] opa = 64'h0;
    logic [63:0] opb = 64'h0;
    logic [31:0] ctl_in = 32'h0;
    logic [63:0] result;
    logic        valid_out;
    logic        illegal_out;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    pixfmt_unit u_pixfmt_unit (
        .clk(clk), .rst_n(rst_n), .valid_in(valid_in), .op_code(op_code),
        .opa(opa), .opb(opb), .ctl_in(ctl_in),
        .result(result), .valid_out(valid_out), .illegal_out(illegal_out)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic longint clampv(input longint v, input longint lo, input longint hi);
        return (v < lo) ? lo : ((v > hi) ? hi : v);
    endfunction

    function automatic logic [63:0] exp_p16(input logic [63:0] b, input int sc);
        logic [63:0] r = 64'h0;
        for (int i = 0; i < 4; i++) begin
            longint s = longint'($signed(b[16*i +: 16]));
            longint v = clampv((s <<< sc) >>> 7, 0, 255);
            r[8*i +: 8] = v[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_p32(input logic [63:0] a, input logic [63:0] b, input int sc);
        logic [63:0] r = (a << 8) & ~64'h0000_00FF_0000_00FF;
        for (int i = 0; i < 2; i++) begin
            longint s = longint'($signed(b[32*i +: 32]));
            longint v = clampv((s <<< sc) >>> 23, 0, 255);
            r[32*i +: 8] = v[7:0];
        end
        return r;
    endfunction

    function automatic logic [63:0] exp_fix(input logic [63:0] b, input int sc);
        logic [63:0] r = 64'h0;
        for (int i = 0; i < 2; i++) begin
            longint s = longint'($signed(b[32*i +: 32]));
            longint v = clampv((s <<< sc) >>> 16, -32768, 32767);
            r[16*i +: 16] = v[15:0];
        end
        return r;
    endfunction

    // Issue one operation and check the registered outputs one cycle later.
    task automatic run(input logic [8:0] op, input logic [63:0] a, input logic [63:0] b,
                       input logic [31:0] c, input logic [63:0] exp, input logic exp_ill,
                       input string req);
        @(negedge clk);
        valid_in = 1'b1; op_code = op; opa = a; opb = b; ctl_in = c;
        @(negedge clk);
        check(req, result, exp);
        check({req, " flag"}, {62'h0, valid_out, illegal_out}, {62'h0, 1'b1, exp_ill});
    endtask

    function automatic logic [63:0] pick(input int k);
        case (k)
            0: return 64'h7FFF_8000_0001_FFFF;
            1: return 64'h0100_00FF_0080_007F;
            2: return 64'h8000_0000_7FFF_FFFF;
            3: return 64'h0000_0000_0000_0000;
            default: return {$urandom(), $urandom()};
        endcase
    endfunction

    initial begin : watchdog
        #(4 * 150000);
        bad++; total++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [63:0] a, b, e, last;
        logic [31:0] c;
        // R1: reset clears outputs even with an operation presented
        valid_in = 1'b1; op_code = 9'h04B; opa = '1; opb = '1;
        repeat (3) @(negedge clk);
        check("R1 reset", {result[61:0], valid_out, illegal_out}, 64'h0);
        valid_in = 1'b0;
        rst_n = 1'b1;

        // R3 R8 R10: pack16 over every scale, junk in unused control bits
        for (int sc = 0; sc < 16; sc++) begin
            for (int k = 0; k < 8; k++) begin
                b = pick(k); a = {$urandom(), $urandom()};
                c = {$urandom()} & ~32'h0000_0078 | (32'(sc) << 3);
                run(9'h03B, a, b, c, exp_p16(b, sc), 1'b0, "R3 pack16");
            end
        end
        // R4 R8 R10: pack32 over every scale
        for (int sc = 0; sc < 32; sc++) begin
            for (int k = 0; k < 6; k++) begin
                b = pick(k); a = {$urandom(), $urandom()};
                c = {$urandom()} & ~32'h0000_00F8 | (32'(sc) << 3);
                run(9'h03A, a, b, c, exp_p32(a, b, sc), 1'b0, "R4 pack32");
            end
        end
        // R5 R8 R10: fixed pack over every scale
        for (int sc = 0; sc < 32; sc++) begin
            for (int k = 0; k < 6; k++) begin
                b = pick(k); a = {$urandom(), $urandom()};
                c = {$urandom()} & ~32'h0000_00F8 | (32'(sc) << 3);
                run(9'h03D, a, b, c, exp_fix(b, sc), 1'b0, "R5 fixpack");
            end
        end
        // R6 R7: expand and merge with corner and random words
        for (int k = 0; k < 40; k++) begin
            a = pick(k % 6); b = {$urandom(), $urandom()};
            if (k == 1) b = 64'hFFFF_FFFF_FFFF_FFFF;
            e = 64'h0;
            for (int i = 0; i < 4; i++) e[16*i +: 16] = {4'h0, b[8*i +: 8], 4'h0};
            run(9'h04D, a, b, {$urandom()}, e, 1'b0, "R6 expand");
            e = 64'h0;
            for (int i = 0; i < 4; i++) e[16*i +: 16] = {a[8*i +: 8], b[8*i +: 8]};
            run(9'h04B, a, b, {$urandom()}, e, 1'b0, "R7 merge");
        end
        // R2: unrecognised codes give zero and the flag
        run(9'h000, '1, '1, '1, 64'h0, 1'b1, "R2 illegal 000");
        run(9'h03C, '1, '1, '1, 64'h0, 1'b1, "R2 illegal 03C");
        run(9'h04C, '1, '1, '1, 64'h0, 1'b1, "R2 illegal 04C");
        run(9'h1FF, '1, '1, '1, 64'h0, 1'b1, "R2 illegal 1FF");
        // R9: idle cycles hold the result and keep the flag low
        run(9'h04B, 64'h0, 64'h0000_0000_1234_5678, 32'h0, 64'h0012_0034_0056_0078, 1'b0, "R9 setup");
        last = 64'h0012_0034_0056_0078;
        @(negedge clk);
        valid_in = 1'b0; op_code = 9'h1FF; opa = '1; opb = '1;
        @(negedge clk);
        check("R9 hold result", result, last);
        check("R9 idle flags", {62'h0, valid_out, illegal_out}, 64'h0);
        op_code = 9'h03B;
        @(negedge clk);
        check("R9 hold again", result, last);
        // R1: valid returns one cycle after reissue
        run(9'h03B, 64'h0, 64'h0, 32'h0, 64'h0, 1'b0, "R1 reissue");
        valid_in = 1'b0;
        @(negedge clk);
        check("R1 valid drop", {63'h0, valid_out}, 64'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule